// File: doc/BRIEF.md
# System Control and Exception Status Register Block

This block is the software-visible system control register page of a small microcontroller core. A single-cycle register bus writes and reads a handful of 32-bit registers. Writes become one-cycle request strobes toward the interrupt controller: set or clear pending for the non-maskable interrupt, the pendable service call and the periodic tick. Writes also update the vector base, enable the fault handlers and pulse a system reset request. Reads build status words from the live exception state that the interrupt controller drives in.

Read data is combinational: `bus_rdata` follows `bus_addr` and the status inputs in the same cycle. Every write takes effect on the clock edge that samples `bus_wr`. Each strobe output is high for the one cycle after that edge. Arbitration and priority between interrupts stay in the interrupt controller.

Offsets used (12-bit byte address):
- 0x004: controller type.
- 0xD04: interrupt control/state.
- 0xD08: vector base.
- 0xD0C: reset control.
- 0xD24: handler control/state.
- 0xF00: software trigger.

Top module: `sysctl_regs`

## Requirements
- R1: A write to 0xD04 with bit31 set gives `nmi_set` high for the next cycle. Bit28 gives `pendsv_set`. Bit27 gives `pendsv_clr`, but only when bit28 of the same write is clear.
- R2: A write to 0xD04 with bit26 set gives `systick_set` high for the next cycle. Bit25 gives `systick_clr`, but only when bit26 of the same write is clear.
- R3: A read of 0xD04 assembles these fields:
  - bits 8:0: the active vector.
  - bit 11: `other_active`.
  - bits 20:12: the pending vector.
  - bit 22: `ext_pend_any`.
  - bit 26: `core_pend[0]` (tick pending).
  - bit 28: `core_pend[1]` (service call pending).
  - bit 31: `core_pend[2]` (NMI pending).
  - All other bits read zero.
- R4: An active vector of 0 or 1023 reads as 0 in the active field. A pending vector of 1023 reads as 0 in the pending field.
- R5: A write to 0xD08 stores the data with bits 6:0 forced to zero. The stored value appears on `vtor_base` and reads back at 0xD08.
- R6: A write to 0xD0C whose bits 31:16 equal 0x05FA and whose bit2 is set raises `sysreset_req` for exactly the next cycle. Any other key produces no pulse.
- R7: A read of 0xD0C returns 0xFA050000.
- R8: At 0xD24, write bits 16, 17 and 18 store the enables for the memory-management, bus and usage fault handlers. These drive `fault_en[0..2]` and read back at the same bits.
- R9: A read of 0xD24 returns the active flags and the pending flags as follows:
  - `hdl_active[6:0]` (memory, bus, usage, service call, debug, pendable service, tick) at bits 0, 1, 3, 7, 8, 10 and 11.
  - `hdl_pend[3:0]` (usage, memory, bus, service call) at bits 12 to 15.
- R10: A write to 0xF00 takes bits 8:0 as an interrupt number. If that number is below NUM_IRQ, `swirq_valid` pulses for the next cycle with the number on `swirq_num`. Otherwise the write is ignored.
- R11: A read of 0x004 returns NUM_IRQ/32 - 1.
- R12: Unmapped offsets and the write-only trigger register read as zero, and writes to unmapped offsets change nothing. After reset, all outputs and the stored state are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| exc_active | input | VEC_W | Vector currently in service (1023 = none) |
| exc_pending | input | VEC_W | Highest pending vector (1023 = none) |
| ext_pend_any | input | 1 | Some external interrupt is pending |
| other_active | input | 1 | A handler besides the current one is active |
| hdl_active | input | 7 | Active flags: mem, bus, usage, svc, debug, pendable svc, tick |
| hdl_pend | input | 4 | Pending flags: usage, mem, bus, svc |
| core_pend | input | 3 | Pending state of tick, pendable svc, NMI |
| nmi_set | output | 1 | NMI set-pending strobe |
| pendsv_set | output | 1 | Pendable service call set-pending strobe |
| pendsv_clr | output | 1 | Pendable service call clear-pending strobe |
| systick_set | output | 1 | Tick set-pending strobe |
| systick_clr | output | 1 | Tick clear-pending strobe |
| fault_en | output | 3 | Enables for mem, bus, usage fault handlers |
| vtor_base | output | 32 | Vector table base address |
| sysreset_req | output | 1 | One-cycle system reset request |
| swirq_valid | output | 1 | Software trigger strobe |
| swirq_num | output | 9 | Interrupt number for the software trigger |

## Verification
The control/state write is driven with three bit patterns, each of which separates two possible orderings of set and clear:
- all three set bits together;
- set and clear bits for the same source together, which shows whether set wins;
- clear bits alone.

The status read is driven with these vector values:
- a busy state with every flag set;
- the idle code 1023 on both vectors;
- a zero active vector beside a real pending number.

Together these tell the idle-to-zero mapping apart from plain truncation. The reset key is tried correct, off by one and with no reset bit. The software trigger is tried at the last legal number, at the first illegal one, at the maximum and with high junk bits above the field.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] OFF_CTYPE  = 12'h004;
   localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'hD04;
   localparam logic [ADDR_W-1:0] OFF_VBASE  = 12'hD08;
   localparam logic [ADDR_W-1:0] OFF_RSTCTL = 12'hD0C;
   localparam logic [ADDR_W-1:0] OFF_HDL    = 12'hD24;
   localparam logic [ADDR_W-1:0] OFF_TRIG   = 12'hF00;

   localparam logic [15:0]       RST_KEY    = 16'h05FA;
   localparam logic [DATA_W-1:0] RSTCTL_RD  = 32'hFA05_0000;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_CTYPE,
      SEL_CTRL,
      SEL_VBASE,
      SEL_RSTCTL,
      SEL_HDL,
      SEL_TRIG
   } reg_sel_e;

   function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
      case (a)
         OFF_CTYPE:  return SEL_CTYPE;
         OFF_CTRL:   return SEL_CTRL;
         OFF_VBASE:  return SEL_VBASE;
         OFF_RSTCTL: return SEL_RSTCTL;
         OFF_HDL:    return SEL_HDL;
         OFF_TRIG:   return SEL_TRIG;
         default:    return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/sysctl_icsr.sv
module sysctl_icsr #(
   parameter int VEC_W    = 10,
   parameter int IDLE_VEC = 1023,
   parameter int FIELD_W  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [31:25]     wbits,
   input  logic [VEC_W-1:0] exc_active,
   input  logic [VEC_W-1:0] exc_pending,
   input  logic             ext_pend_any,
   input  logic             other_active,
   input  logic [2:0]       core_pend,
   output logic [31:0]      rd_word,
   output logic             nmi_set,
   output logic             pendsv_set,
   output logic             pendsv_clr,
   output logic             systick_set,
   output logic             systick_clr
);

   localparam logic [VEC_W-1:0] IDLE = VEC_W'(IDLE_VEC);

   logic [FIELD_W-1:0] act_f;
   logic [FIELD_W-1:0] pend_f;

   always_comb begin
      act_f  = (exc_active == IDLE || exc_active == '0) ? '0 : exc_active[FIELD_W-1:0];
      pend_f = (exc_pending == IDLE) ? '0 : exc_pending[FIELD_W-1:0];
   end

   always_comb begin
      rd_word                   = '0;
      rd_word[FIELD_W-1:0]      = act_f;
      rd_word[11]               = other_active;
      rd_word[12 +: FIELD_W]    = pend_f;
      rd_word[22]               = ext_pend_any;
      rd_word[26]               = core_pend[0];
      rd_word[28]               = core_pend[1];
      rd_word[31]               = core_pend[2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_set     <= 1'b0;
         pendsv_set  <= 1'b0;
         pendsv_clr  <= 1'b0;
         systick_set <= 1'b0;
         systick_clr <= 1'b0;
      end else begin
         nmi_set     <= wr_en & wbits[31];
         pendsv_set  <= wr_en & wbits[28];
         pendsv_clr  <= wr_en & wbits[27] & ~wbits[28];
         systick_set <= wr_en & wbits[26];
         systick_clr <= wr_en & wbits[25] & ~wbits[26];
      end
   end

   assert_pendsv_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wbits[28]) |=> (pendsv_set && !pendsv_clr));
   assert_nmi_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wbits[31]) |=> nmi_set);
   assert_systick_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wbits[26]) |=> (systick_set && !systick_clr));
   assert_no_strobe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> !(nmi_set || pendsv_set || pendsv_clr || systick_set || systick_clr));

endmodule

// File: rtl/sysctl_cfg.sv
module sysctl_cfg #(
   parameter int ALIGN_BITS = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        vbase_wr,
   input  logic        rstctl_wr,
   input  logic        hdl_wr,
   input  logic [31:0] wdata,
   input  logic [6:0]  hdl_active,
   input  logic [3:0]  hdl_pend,
   output logic [31:0] vtor_base,
   output logic [2:0]  fault_en,
   output logic        sysreset_req,
   output logic [31:0] hdl_word
);

   import sysctl_pkg::*;

   localparam logic [31:0] VMASK = ~((32'd1 << ALIGN_BITS) - 32'd1);
   localparam int          EN_LSB = 16;
   localparam int          ACT_POS [7] = '{0, 1, 3, 7, 8, 10, 11};
   localparam int          PEND_LSB = 12;

   logic key_ok;
   assign key_ok = (wdata[31:16] == RST_KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vtor_base    <= '0;
         sysreset_req <= 1'b0;
      end else begin
         if (vbase_wr) vtor_base <= wdata & VMASK;
         sysreset_req <= rstctl_wr & key_ok & wdata[2];
      end
   end

   for (genvar g = 0; g < 3; g++) begin : g_fault_en
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      fault_en[g] <= 1'b0;
         else if (hdl_wr) fault_en[g] <= wdata[EN_LSB + g];
      end
   end

   always_comb begin
      hdl_word = '0;
      for (int i = 0; i < 7; i++) hdl_word[ACT_POS[i]] = hdl_active[i];
      hdl_word[PEND_LSB +: 4]  = hdl_pend;
      hdl_word[EN_LSB +: 3]    = fault_en;
   end

   assert_vbase_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
      vbase_wr |=> (vtor_base == ($past(wdata) & VMASK)));
   assert_reset_keyed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sysreset_req |-> $past(rstctl_wr && wdata[31:16] == RST_KEY && wdata[2]));
   assert_fault_en_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hdl_wr |=> $stable(fault_en));

endmodule

// File: rtl/sysctl_swtrig.sv
module sysctl_swtrig #(
   parameter int NUM_IRQ = 64,
   parameter int NUM_W   = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [NUM_W-1:0] num_in,
   output logic             swirq_valid,
   output logic [NUM_W-1:0] swirq_num
);

   localparam logic [NUM_W:0] LIMIT = (NUM_W+1)'(NUM_IRQ);

   logic in_range;
   assign in_range = ({1'b0, num_in} < LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         swirq_valid <= 1'b0;
         swirq_num   <= '0;
      end else begin
         swirq_valid <= wr_en & in_range;
         if (wr_en && in_range) swirq_num <= num_in;
      end
   end

   assert_swirq_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      swirq_valid |-> ({1'b0, swirq_num} < LIMIT));
   assert_swirq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      swirq_valid |-> $past(wr_en));

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
   parameter int NUM_IRQ    = 64,
   parameter int VEC_W      = 10,
   parameter int IDLE_VEC   = 1023,
   parameter int ALIGN_BITS = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [11:0]      bus_addr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   input  logic [VEC_W-1:0] exc_active,
   input  logic [VEC_W-1:0] exc_pending,
   input  logic             ext_pend_any,
   input  logic             other_active,
   input  logic [6:0]       hdl_active,
   input  logic [3:0]       hdl_pend,
   input  logic [2:0]       core_pend,
   output logic             nmi_set,
   output logic             pendsv_set,
   output logic             pendsv_clr,
   output logic             systick_set,
   output logic             systick_clr,
   output logic [2:0]       fault_en,
   output logic [31:0]      vtor_base,
   output logic             sysreset_req,
   output logic             swirq_valid,
   output logic [8:0]       swirq_num
);

   import sysctl_pkg::*;

   localparam int          NUM_W   = 9;
   localparam int          FIELD_W = 9;
   localparam logic [31:0] CTYPE_VAL = 32'(NUM_IRQ / 32 - 1);

   if (NUM_IRQ < 32 || NUM_IRQ > 512 || (NUM_IRQ % 32) != 0) begin : g_bad_irq
      $error("NUM_IRQ must be a multiple of 32 in 32..512");
   end
   if (VEC_W < FIELD_W + 1 || VEC_W > 16) begin : g_bad_vec
      $error("VEC_W must lie in 10..16");
   end
   if (ALIGN_BITS < 1 || ALIGN_BITS > 16) begin : g_bad_align
      $error("ALIGN_BITS must lie in 1..16");
   end

   reg_sel_e    sel;
   logic [31:0] ctrl_word;
   logic [31:0] hdl_word;

   assign sel = decode(bus_addr);

   sysctl_icsr #(.VEC_W(VEC_W), .IDLE_VEC(IDLE_VEC), .FIELD_W(FIELD_W)) u_icsr (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (bus_wr && sel == SEL_CTRL),
      .wbits        (bus_wdata[31:25]),
      .exc_active   (exc_active),
      .exc_pending  (exc_pending),
      .ext_pend_any (ext_pend_any),
      .other_active (other_active),
      .core_pend    (core_pend),
      .rd_word      (ctrl_word),
      .nmi_set      (nmi_set),
      .pendsv_set   (pendsv_set),
      .pendsv_clr   (pendsv_clr),
      .systick_set  (systick_set),
      .systick_clr  (systick_clr)
   );

   sysctl_cfg #(.ALIGN_BITS(ALIGN_BITS)) u_cfg (
      .clk          (clk),
      .rst_n        (rst_n),
      .vbase_wr     (bus_wr && sel == SEL_VBASE),
      .rstctl_wr    (bus_wr && sel == SEL_RSTCTL),
      .hdl_wr       (bus_wr && sel == SEL_HDL),
      .wdata        (bus_wdata),
      .hdl_active   (hdl_active),
      .hdl_pend     (hdl_pend),
      .vtor_base    (vtor_base),
      .fault_en     (fault_en),
      .sysreset_req (sysreset_req),
      .hdl_word     (hdl_word)
   );

   sysctl_swtrig #(.NUM_IRQ(NUM_IRQ), .NUM_W(NUM_W)) u_trig (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (bus_wr && sel == SEL_TRIG),
      .num_in      (bus_wdata[NUM_W-1:0]),
      .swirq_valid (swirq_valid),
      .swirq_num   (swirq_num)
   );

   always_comb begin
      case (sel)
         SEL_CTYPE:  bus_rdata = CTYPE_VAL;
         SEL_CTRL:   bus_rdata = ctrl_word;
         SEL_VBASE:  bus_rdata = vtor_base;
         SEL_RSTCTL: bus_rdata = RSTCTL_RD;
         SEL_HDL:    bus_rdata = hdl_word;
         default:    bus_rdata = '0;
      endcase
   end

   assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE || sel == SEL_TRIG) |-> (bus_rdata == '0));
   assert_rstctl_const_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_RSTCTL) |-> (bus_rdata == 32'hFA05_0000));

endmodule

// File: tb/tb_sysctl_regs.sv
module tb_sysctl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [9:0]  exc_active = '0;
   logic [9:0]  exc_pending = '0;
   logic        ext_pend_any = 1'b0;
   logic        other_active = 1'b0;
   logic [6:0]  hdl_active = '0;
   logic [3:0]  hdl_pend = '0;
   logic [2:0]  core_pend = '0;
   logic        nmi_set, pendsv_set, pendsv_clr, systick_set, systick_clr;
   logic [2:0]  fault_en;
   logic [31:0] vtor_base;
   logic        sysreset_req;
   logic        swirq_valid;
   logic [8:0]  swirq_num;

   int n_checks = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   sysctl_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .exc_active(exc_active), .exc_pending(exc_pending),
      .ext_pend_any(ext_pend_any), .other_active(other_active),
      .hdl_active(hdl_active), .hdl_pend(hdl_pend), .core_pend(core_pend),
      .nmi_set(nmi_set), .pendsv_set(pendsv_set), .pendsv_clr(pendsv_clr),
      .systick_set(systick_set), .systick_clr(systick_clr),
      .fault_en(fault_en), .vtor_base(vtor_base), .sysreset_req(sysreset_req),
      .swirq_valid(swirq_valid), .swirq_num(swirq_num)
   );

   localparam logic [11:0] T_ADDR [8] = '{12'hD08, 12'hD08, 12'hD24, 12'hD24,
                                         12'hD0C, 12'h010, 12'h004, 12'hF00};
   localparam logic [31:0] T_WDATA [8] = '{32'h2000_01FF, 32'hFFFF_FFFF,
                                          32'h0007_0000, 32'h0005_FFFF,
                                          32'h05FA_0000, 32'hFFFF_FFFF,
                                          32'hFFFF_FFFF, 32'h0000_0003};
   localparam logic [31:0] T_EXP [8] = '{32'h2000_0180, 32'hFFFF_FF80,
                                        32'h0007_0000, 32'h0005_0000,
                                        32'hFA05_0000, 32'h0000_0000,
                                        32'h0000_0001, 32'h0000_0000};
   localparam string T_REQ [8] = '{"R5", "R5", "R8", "R8", "R7", "R12", "R11", "R12"};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   function automatic logic [31:0] strobes();
      return {27'd0, nmi_set, pendsv_set, pendsv_clr, systick_set, systick_clr};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12", strobes(), 32'd0);
      chk("R12", {28'd0, fault_en, sysreset_req}, 32'd0);
      chk("R12", vtor_base, 32'd0);
      chk("R12", {22'd0, swirq_valid, swirq_num}, 32'd0);
      rd_chk(12'hD24, 32'd0, "R12");
      rd_chk(12'hD08, 32'd0, "R12");

      // table walk: write then read back
      for (int i = 0; i < 8; i++) begin
         wr(T_ADDR[i], T_WDATA[i]);
         rd_chk(T_ADDR[i], T_EXP[i], T_REQ[i]);
      end
      chk("R5", vtor_base, 32'hFFFF_FF80);
      chk("R8", {29'd0, fault_en}, 32'd5);

      // R1 R2: strobe bit order nmi,pendsv_set,pendsv_clr,systick_set,systick_clr
      wr(12'hD04, 32'h9400_0000);
      chk("R1", strobes(), 32'b11010);
      @(negedge clk);
      chk("R1", strobes(), 32'd0);
      wr(12'hD04, 32'h1A00_0000);
      chk("R2", strobes(), 32'b01001);
      wr(12'hD04, 32'h0A00_0000);
      chk("R1", strobes(), 32'b00101);
      wr(12'hD08, 32'h8000_0000);
      chk("R12", strobes(), 32'd0);

      // R3 R4 status assembly
      exc_active = 10'h013; exc_pending = 10'h02A;
      ext_pend_any = 1'b1; other_active = 1'b1; core_pend = 3'b111;
      rd_chk(12'hD04, 32'h9442_A813, "R3");
      exc_active = 10'h3FF; exc_pending = 10'h3FF;
      ext_pend_any = 1'b0; other_active = 1'b0; core_pend = 3'b000;
      rd_chk(12'hD04, 32'h0000_0000, "R4");
      exc_active = 10'h000; exc_pending = 10'h005; core_pend = 3'b010;
      rd_chk(12'hD04, 32'h1000_5000, "R4");

      // R9 handler status with enables 101
      hdl_active = 7'h7F; hdl_pend = 4'hF;
      rd_chk(12'hD24, 32'h0005_FD8B, "R9");
      hdl_active = 7'b0100101; hdl_pend = 4'b1010;
      rd_chk(12'hD24, 32'h0005_A409, "R9");

      // R6 keyed reset pulse
      wr(12'hD0C, 32'h05FA_0004);
      chk("R6", {31'd0, sysreset_req}, 32'd1);
      @(negedge clk);
      chk("R6", {31'd0, sysreset_req}, 32'd0);
      wr(12'hD0C, 32'h05FB_0004);
      chk("R6", {31'd0, sysreset_req}, 32'd0);
      wr(12'hD0C, 32'h05FA_0000);
      chk("R6", {31'd0, sysreset_req}, 32'd0);

      // R10 software trigger, NUM_IRQ = 64
      wr(12'hF00, 32'h0000_0025);
      chk("R10", {22'd0, swirq_valid, swirq_num}, {22'd0, 1'b1, 9'd37});
      wr(12'hF00, 32'h0000_0040);
      chk("R10", {31'd0, swirq_valid}, 32'd0);
      wr(12'hF00, 32'h0000_023F);
      chk("R10", {22'd0, swirq_valid, swirq_num}, {22'd0, 1'b1, 9'd63});
      wr(12'hF00, 32'h0000_01FF);
      chk("R10", {22'd0, swirq_valid, swirq_num}, {22'd0, 1'b0, 9'd63});

      // R12 unmapped write leaves state alone
      wr(12'hD28, 32'hFFFF_FFFF);
      chk("R12", vtor_base, 32'h8000_0000);
      chk("R12", {29'd0, fault_en}, 32'd5);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule